// File: doc/BRIEF.md
# Transport Stream Packet Synchroniser

This block finds packet boundaries in an incoming transport stream and frames the stream into byte-aligned packets. The stream arrives either as bytes on an 8-bit bus or as single bits on bit 0 of that bus. In the bit mode the bits are gathered most significant bit first. The block watches for a programmable sync byte that repeats every `PKT_LEN` bytes. It counts how many packets in a row begin with that byte. Once the count reaches a programmable lock threshold, it starts delivering packets.

While locked, every byte goes out with a start-of-packet marker on the first byte of each packet. A packet whose first byte is not the sync byte is still delivered, but with an error flag on all of its bytes. Lock is given up after a programmable number of such packets in a row, and the search starts again.

Input capture is configurable. In clocked mode a byte or bit is taken on the selected edge of the stream clock while the valid line is high. In strobe mode each rising edge of the valid line takes one byte or bit, and the stream clock is not used. All logic runs in the system clock domain, and the stream clock and valid line are sampled as data.

Top module: `ts_sync_lock`

## Requirements
- R1: In clocked mode (`cfg_async`=0) one unit (a byte, or a bit in serial mode) is taken on each active edge of `ts_clk` that finds `ts_valid` high; edges with `ts_valid` low take nothing and leave framing unchanged.
- R2: With `cfg_clk_inv`=0 the active edge is the rising edge of `ts_clk`; with `cfg_clk_inv`=1 it is the falling edge.
- R3: In strobe mode (`cfg_async`=1) one unit is taken on each rising edge of `ts_valid`, and `ts_clk` has no effect.
- R4: With `cfg_serial`=1 the unit is `ts_data[0]` and bytes are built MSB first. While no packet start is known, every bit position is tried as the last bit of a sync byte, once at least 8 bits have arrived. After a match, bytes are framed in groups of 8 bits counted from the bit after the match.
- R5: While searching, any byte equal to `cfg_token` becomes a candidate start. The candidate is kept only if `cfg_token` appears again exactly `PKT_LEN` bytes later. Otherwise the search resumes from the byte after the failed check.
- R6: Lock is declared when `cfg_lock_thr` packets in a row begin with `cfg_token`, with values 0 and 1 both meaning 1. `locked` rises in the same cycle as the first output byte, which is the sync byte that reached the count, with `out_sop`=1.
- R7: `out_valid` is never high while `locked` is low.
- R8: While locked, each input byte appears once on `out_data` with `out_valid` high and `out_sop` high on packet byte 0. If byte 0 differs from `cfg_token`, `out_err` is high on every byte of that packet; otherwise it is low.
- R9: Lock is dropped when `cfg_drop_thr` packets in a row (0 treated as 1) begin with a byte other than `cfg_token`. A good packet start clears the miss count. The packet that completes the count is not output, and `locked` falls with `out_valid` low.
- R10: During and after reset, `locked` and `out_valid` are low.
- R11: The sync byte is the value on `cfg_token` (nominally 0x47). Any other value, including 0x47 when the token differs, counts as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_serial | input | 1 | 1: serial bit input on ts_data[0]; 0: byte input |
| cfg_clk_inv | input | 1 | 1: sample on falling ts_clk edge; 0: rising |
| cfg_async | input | 1 | 1: rising edge of ts_valid is the strobe; 0: ts_clk edge qualified by ts_valid |
| cfg_token | input | 8 | Sync byte value |
| cfg_lock_thr | input | THR_W | Consecutive good packet starts needed for lock |
| cfg_drop_thr | input | THR_W | Consecutive bad packet starts that drop lock |
| ts_clk | input | 1 | Stream clock, sampled by clk |
| ts_valid | input | 1 | Stream valid or strobe |
| ts_data | input | 8 | Stream data (bit 0 in serial mode) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_err | output | 1 | Packet did not start with the sync byte |
| locked | output | 1 | Packet lock held |

## Verification
A sweep over lock and drop thresholds, zero included, checks that output starts on exactly the right packet and ends one packet before the drop. A block that counted the first candidate twice, or treated a threshold of 0 as "never", would start or stop one packet early or late. A false sync byte placed just ahead of the real stream must fail its recurrence check and delay lock by one packet. A block that accepted it would lock one packet early, and a block that accepted the later real tokens without the exact-distance rule would do the same. Serial runs start on an odd bit offset to force bit-level realignment. The inverted-clock runs put junk data on the wrong edge, and the clocked runs slip in strobes with valid low, so a wrong-edge or valid-blind capture corrupts the framed bytes.

// File: rtl/ts_lock_pkg.sv
package ts_lock_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SYNC_HUNT   = 2'd0,
        SYNC_VERIFY = 2'd1,
        SYNC_LOCKED = 2'd2
    } sync_state_e;

    // one captured unit: a byte, or a bit carried in val[0]
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] val;
    } lane_t;

    // one framed output byte
    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              err;
        logic [BYTE_W-1:0] val;
    } pkt_beat_t;

    // threshold compare; a zero threshold behaves as one
    function automatic logic count_reached(input logic [15:0] cnt, input logic [15:0] thr);
        logic [15:0] eff;
        eff = (thr == 16'd0) ? 16'd1 : thr;
        return cnt >= eff;
    endfunction

    // MSB-first shift: the new bit enters at the bottom
    function automatic logic [BYTE_W-1:0] msb_shift(input logic [BYTE_W-1:0] sr, input logic b);
        return {sr[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/ts_edge_strobe.sv
module ts_edge_strobe
    import ts_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_inv,
    input  logic              async_mode,
    input  logic              ts_clk,
    input  logic              ts_valid,
    input  logic [BYTE_W-1:0] ts_data,
    output lane_t             unit_o
);

    logic              clk_d1, clk_d2;
    logic              vld_d1, vld_d2;
    logic [BYTE_W-1:0] dat_d1;
    logic              fire;
    lane_t             unit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d1 <= 1'b0;
            clk_d2 <= 1'b0;
            vld_d1 <= 1'b0;
            vld_d2 <= 1'b0;
            dat_d1 <= '0;
        end else begin
            clk_d1 <= ts_clk;
            clk_d2 <= clk_d1;
            vld_d1 <= ts_valid;
            vld_d2 <= vld_d1;
            dat_d1 <= ts_data;
        end
    end

    always_comb begin
        if (async_mode)
            fire = vld_d1 & ~vld_d2;
        else if (clk_inv)
            fire = vld_d1 & clk_d2 & ~clk_d1;
        else
            fire = vld_d1 & ~clk_d2 & clk_d1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            unit_q <= '0;
        else
            unit_q <= '{vld: fire, val: dat_d1};
    end

    assign unit_o = unit_q;

endmodule

// File: rtl/ts_byte_framer.sv
module ts_byte_framer
    import ts_lock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  serial,
    input  logic  hunting,
    input  logic  realign,
    input  lane_t unit_i,
    output lane_t byte_o
);

    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] FULL = CW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] nxt;
    logic [CW-1:0]     fill;
    logic [CW-1:0]     bitcnt;

    assign nxt = msb_shift(sr, unit_i.val[0]);

    always_comb begin
        byte_o.val = serial ? nxt : unit_i.val;
        if (!serial)
            byte_o.vld = unit_i.vld;
        else if (hunting)
            byte_o.vld = unit_i.vld & (fill == FULL);
        else
            byte_o.vld = unit_i.vld & (bitcnt == FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr     <= '0;
            fill   <= '0;
            bitcnt <= '0;
        end else if (unit_i.vld && serial) begin
            sr <= nxt;
            if (fill != FULL)
                fill <= fill + 1'b1;
            if (realign)
                bitcnt <= '0;
            else if (!hunting)
                bitcnt <= bitcnt + 1'b1;
        end
    end

endmodule

// File: rtl/ts_sync_fsm.sv
module ts_sync_fsm
    import ts_lock_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int THR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] token,
    input  logic [THR_W-1:0]  lock_thr,
    input  logic [THR_W-1:0]  drop_thr,
    input  lane_t             byte_i,
    output logic              hunting,
    output logic              realign,
    output logic              locked,
    output pkt_beat_t         beat_o
);

    localparam int POS_W = $clog2(PKT_LEN);
    localparam logic [POS_W-1:0] LAST = POS_W'(PKT_LEN - 1);

    sync_state_e      st, st_n;
    logic [POS_W-1:0] pos, pos_n, pos_step;
    logic [THR_W-1:0] good_cnt, good_n, miss_cnt, miss_n;
    logic             pkt_err, err_n;
    pkt_beat_t        beat_q, beat_n;
    logic             is_tok;

    assign is_tok   = (byte_i.val == token);
    assign hunting  = (st == SYNC_HUNT);
    assign realign  = hunting & byte_i.vld & is_tok;
    assign locked   = (st == SYNC_LOCKED);
    assign pos_step = (pos == LAST) ? '0 : pos + 1'b1;
    assign beat_o   = beat_q;

    always_comb begin
        st_n   = st;
        pos_n  = pos;
        good_n = good_cnt;
        miss_n = miss_cnt;
        err_n  = pkt_err;
        beat_n = '0;
        if (byte_i.vld) begin
            unique case (st)
                SYNC_HUNT: begin
                    if (is_tok) begin
                        pos_n  = POS_W'(1);
                        good_n = THR_W'(1);
                        miss_n = '0;
                        err_n  = 1'b0;
                        if (count_reached(16'd1, 16'(lock_thr))) begin
                            st_n   = SYNC_LOCKED;
                            beat_n = '{1'b1, 1'b1, 1'b0, byte_i.val};
                        end else begin
                            st_n = SYNC_VERIFY;
                        end
                    end
                end
                SYNC_VERIFY: begin
                    pos_n = pos_step;
                    if (pos == '0) begin
                        if (!is_tok) begin
                            st_n = SYNC_HUNT;
                        end else if (count_reached(16'(good_cnt) + 16'd1, 16'(lock_thr))) begin
                            st_n   = SYNC_LOCKED;
                            miss_n = '0;
                            err_n  = 1'b0;
                            beat_n = '{1'b1, 1'b1, 1'b0, byte_i.val};
                        end else begin
                            good_n = good_cnt + 1'b1;
                        end
                    end
                end
                SYNC_LOCKED: begin
                    pos_n = pos_step;
                    if (pos == '0) begin
                        if (is_tok) begin
                            miss_n = '0;
                            err_n  = 1'b0;
                            beat_n = '{1'b1, 1'b1, 1'b0, byte_i.val};
                        end else if (count_reached(16'(miss_cnt) + 16'd1, 16'(drop_thr))) begin
                            st_n   = SYNC_HUNT;
                            miss_n = '0;
                        end else begin
                            miss_n = miss_cnt + 1'b1;
                            err_n  = 1'b1;
                            beat_n = '{1'b1, 1'b1, 1'b1, byte_i.val};
                        end
                    end else begin
                        beat_n = '{1'b1, 1'b0, pkt_err, byte_i.val};
                    end
                end
                default: st_n = SYNC_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SYNC_HUNT;
            pos      <= '0;
            good_cnt <= '0;
            miss_cnt <= '0;
            pkt_err  <= 1'b0;
            beat_q   <= '0;
        end else begin
            st       <= st_n;
            pos      <= pos_n;
            good_cnt <= good_n;
            miss_cnt <= miss_n;
            pkt_err  <= err_n;
            beat_q   <= beat_n;
        end
    end

endmodule

// File: rtl/ts_sync_lock.sv
module ts_sync_lock
    import ts_lock_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int THR_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_serial,
    input  logic             cfg_clk_inv,
    input  logic             cfg_async,
    input  logic [7:0]       cfg_token,
    input  logic [THR_W-1:0] cfg_lock_thr,
    input  logic [THR_W-1:0] cfg_drop_thr,
    input  logic             ts_clk,
    input  logic             ts_valid,
    input  logic [7:0]       ts_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_err,
    output logic             locked
);

    lane_t     unit_w;
    lane_t     byte_w;
    pkt_beat_t beat_w;
    logic      hunting_w;
    logic      realign_w;

    ts_edge_strobe u_strobe (
        .clk        (clk),
        .rst        (rst),
        .clk_inv    (cfg_clk_inv),
        .async_mode (cfg_async),
        .ts_clk     (ts_clk),
        .ts_valid   (ts_valid),
        .ts_data    (ts_data),
        .unit_o     (unit_w)
    );

    ts_byte_framer u_framer (
        .clk     (clk),
        .rst     (rst),
        .serial  (cfg_serial),
        .hunting (hunting_w),
        .realign (realign_w),
        .unit_i  (unit_w),
        .byte_o  (byte_w)
    );

    ts_sync_fsm #(
        .PKT_LEN (PKT_LEN),
        .THR_W   (THR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .token    (cfg_token),
        .lock_thr (cfg_lock_thr),
        .drop_thr (cfg_drop_thr),
        .byte_i   (byte_w),
        .hunting  (hunting_w),
        .realign  (realign_w),
        .locked   (locked),
        .beat_o   (beat_w)
    );

    assign out_valid = beat_w.vld;
    assign out_sop   = beat_w.sop;
    assign out_err   = beat_w.err;
    assign out_data  = beat_w.val;

endmodule

// File: rtl/ts_sync_lock_chk.sv
module ts_sync_lock_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_token,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sop,
    input logic       out_err,
    input logic       locked
);

    // R7: nothing leaves the block without lock
    a_r7_out_needs_lock: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> locked);

    // R6: lock begins on a clean packet start
    a_r6_lock_at_sop: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (out_valid && out_sop && !out_err));

    // R9: the packet that drops lock is swallowed
    a_r9_drop_silent: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> !out_valid);

    // R8: clean packet start carries the token
    a_r8_good_header: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && !out_err) |-> (out_data == cfg_token));

    // R8: flagged packet start does not carry the token
    a_r8_bad_header: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && out_err) |-> (out_data != cfg_token));

    // R10: reset clears lock and output
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!locked && !out_valid));

endmodule

bind ts_sync_lock ts_sync_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_token (cfg_token),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_err   (out_err),
    .locked    (locked)
);

// File: tb/sim_ts_sync_lock.sv
`timescale 1ns/1ps
module sim_ts_sync_lock;

    localparam int L = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_serial = 1'b0, cfg_clk_inv = 1'b0, cfg_async = 1'b0;
    logic [7:0] cfg_token = 8'h47;
    logic [3:0] cfg_lock_thr = 4'd3, cfg_drop_thr = 4'd3;
    logic       ts_clk = 1'b0, ts_valid = 1'b0;
    logic [7:0] ts_data = 8'h00;
    logic       out_valid, out_sop, out_err, locked;
    logic [7:0] out_data;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] cap_d [0:4095];
    logic       cap_s [0:4095];
    logic       cap_e [0:4095];
    int         ncap = 0;
    logic [7:0] exp_d [0:4095];
    logic       exp_s [0:4095];
    logic       exp_e [0:4095];
    int         nexp = 0;

    always #2.5 clk = ~clk;

    ts_sync_lock #(.PKT_LEN(L), .THR_W(4)) u0 (
        .clk(clk), .rst(rst), .cfg_serial(cfg_serial), .cfg_clk_inv(cfg_clk_inv),
        .cfg_async(cfg_async), .cfg_token(cfg_token), .cfg_lock_thr(cfg_lock_thr),
        .cfg_drop_thr(cfg_drop_thr), .ts_clk(ts_clk), .ts_valid(ts_valid),
        .ts_data(ts_data), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_err(out_err), .locked(locked)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (ncap < 4096) begin
                cap_d[ncap] = out_data;
                cap_s[ncap] = out_sop;
                cap_e[ncap] = out_err;
            end
            ncap = ncap + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pay(input int p, input int i);
        return 8'(((p * 5 + i) % 15) + 1);
    endfunction

    // one unit on the stream; junk is present on the inactive clock edge
    task automatic put_unit(input logic [7:0] d, input logic vld);
        if (cfg_async) begin
            ts_data  = d;
            ts_valid = 1'b0;
            ts_clk   = ~ts_clk;
            tick(1);
            ts_valid = vld;
            ts_clk   = ~ts_clk;
            tick(1);
        end else begin
            ts_data  = d ^ 8'hFF;
            ts_valid = vld;
            ts_clk   = cfg_clk_inv;
            tick(1);
            ts_data  = d;
            ts_clk   = ~cfg_clk_inv;
            tick(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        if (cfg_serial) begin
            for (int k = 7; k >= 0; k--) put_unit({7'b0, b[k]}, 1'b1);
        end else begin
            put_unit(b, 1'b1);
        end
    endtask

    task automatic push_exp(input logic [7:0] d, input logic s, input logic e);
        exp_d[nexp] = d;
        exp_s[nexp] = s;
        exp_e[nexp] = e;
        nexp++;
    endtask

    task automatic send_pkt(input int p, input bit good, input bit want, input bit noise, input logic [7:0] badv);
        logic [7:0] h;
        h = good ? cfg_token : badv;
        send_byte(h);
        if (want) push_exp(h, 1'b1, !good);
        for (int i = 1; i < L; i++) begin
            // R1: a strobe with valid low must be ignored
            if (noise && i == 5) put_unit(cfg_token, 1'b0);
            send_byte(pay(p, i));
            if (want) push_exp(pay(p, i), 1'b0, !good);
        end
    endtask

    task automatic run_case(input bit ser, input bit inv, input bit asy, input logic [7:0] tok,
                            input int lt, input int dt, input bit fake, input bit noise,
                            input string tag);
        int lte, dte, np, first, bad_d, bad_s, bad_e;
        logic [7:0] badv;
        rst = 1'b1;
        cfg_serial = ser; cfg_clk_inv = inv; cfg_async = asy; cfg_token = tok;
        cfg_lock_thr = 4'(lt); cfg_drop_thr = 4'(dt);
        ts_clk = inv; ts_valid = 1'b0; ts_data = 8'h00;
        tick(4);
        rst = 1'b0;
        tick(1);
        chk(!locked && !out_valid, "R10", {tag, " reset state"}, int'(locked), 0);
        ncap = 0;
        nexp = 0;
        badv = (tok == 8'h47) ? 8'h0A : 8'h47;   // R11: 0x47 is a miss when token differs
        lte = (lt < 1) ? 1 : lt;
        dte = (dt < 1) ? 1 : dt;
        np = lte + 2 * dte + 1;
        first = fake ? lte : lte - 1;
        if (ser) begin
            put_unit(8'h01, 1'b1); put_unit(8'h00, 1'b1); put_unit(8'h01, 1'b1);
        end else begin
            for (int g = 0; g < 3; g++) send_byte(8'h03);
        end
        if (fake) begin
            send_byte(tok);
            for (int g = 0; g < 5; g++) send_byte(8'h02);
        end
        for (int p = 0; p < np; p++) begin
            send_pkt(p, (p <= lte) || (p == lte + dte), (p >= first) && (p <= np - 2), noise, badv);
        end
        tick(8);
        bad_d = 0; bad_s = 0; bad_e = 0;
        for (int k = 0; k < nexp && k < ncap; k++) begin
            if (cap_d[k] !== exp_d[k]) bad_d++;
            if (cap_s[k] !== exp_s[k]) bad_s++;
            if (cap_e[k] !== exp_e[k]) bad_e++;
        end
        chk(ncap == nexp, "R6/R7", {tag, " output byte count"}, ncap, nexp);
        chk(bad_d == 0, "R8", {tag, " data mismatches"}, bad_d, 0);
        chk(bad_s == 0, "R8", {tag, " sop mismatches"}, bad_s, 0);
        chk(bad_e == 0, "R8", {tag, " err mismatches"}, bad_e, 0);
        chk(!locked, "R9", {tag, " lock after drop"}, int'(locked), 0);
    endtask

    initial begin
        // R6 R9: sweep thresholds including zero, byte mode, rising edge
        for (int lt = 0; lt <= 4; lt++)
            for (int dt = 0; dt <= 3; dt++)
                run_case(1'b0, 1'b0, 1'b0, 8'h47, lt, dt, 1'b0, 1'b0, "R6 R9 sweep");
        run_case(1'b0, 1'b1, 1'b0, 8'h47, 3, 2, 1'b0, 1'b0, "R2 falling edge");
        run_case(1'b0, 1'b0, 1'b1, 8'h47, 2, 2, 1'b0, 1'b0, "R3 strobe mode");
        run_case(1'b0, 1'b0, 1'b0, 8'h47, 3, 2, 1'b0, 1'b1, "R1 valid low");
        run_case(1'b0, 1'b1, 1'b0, 8'h47, 2, 3, 1'b0, 1'b1, "R1 R2 valid low inv");
        run_case(1'b0, 1'b0, 1'b0, 8'h47, 3, 1, 1'b1, 1'b0, "R5 false candidate");
        run_case(1'b0, 1'b0, 1'b0, 8'hB8, 2, 2, 1'b0, 1'b0, "R11 other token");
        run_case(1'b1, 1'b0, 1'b0, 8'h47, 3, 2, 1'b0, 1'b0, "R4 serial");
        run_case(1'b1, 1'b1, 1'b0, 8'h47, 2, 3, 1'b0, 1'b0, "R4 R2 serial inv");
        run_case(1'b1, 1'b0, 1'b1, 8'h47, 2, 1, 1'b1, 1'b0, "R4 R5 serial strobe");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule